// File: doc/BRIEF.md
# LCD Panel Vertical Timing Generator

This block produces the row-scan control signals for a 228-row active-matrix LCD panel. It runs on the horizontal section's master clock, where one clock cycle is one timing tick (12 MHz in the intended system). It counts the line strobes that the horizontal section delivers once per line. From the tick position inside the current line and from the line index inside the frame, it decodes these outputs: the vertical start pulse, the 50%-duty vertical shift clock, the gate enable window, and the two letterbox signals (a per-line pulse and a frame-level window).

Two inputs control the scan. The 16:9 mode input thins the picture by suppressing the enable pulse and the shift-clock edge on one line in every four inside the active window. The same input also turns on both letterbox signals. A scan-direction level is passed to the panel as top-to-bottom or bottom-to-top. Both control inputs are captured only at the strobe that begins a new frame, so a change in the middle of a frame never alters the frame in progress.

Ticks are numbered from the line strobe. Tick 0 is the first clock cycle after the cycle in which the strobe is sampled. The tick counter stops at its maximum if no further strobe arrives. The frame is 262 lines long. Lines 33 to 260 form the active window.

Top module: `lcd_vscan_gen`

## Requirements
- R1: After reset, the tick count is parked at its maximum (1023), the line index is 261 and the block is idle: vst_o, vck_o, en_o, wide_line_o and wide_frame_o are 0, and scan_down_o is 1. Each line strobe restarts the tick count at 0 and advances the line index modulo 262. The first strobe after reset starts line 0.
- R2: vck_o changes value at the start of tick 102 of every clocked line. A clocked line is a line in the window 33..260 that is not eliminated. vck_o changes nowhere else. In 4:3 mode a frame has 228 vck_o edges.
- R3: en_o is 1 exactly during ticks 6..71 of every clocked line, which is 66 ticks. It falls 30 ticks before that line's vck_o edge. en_o is 0 on all other lines.
- R4: vst_o is 1 from the start of tick 102 of line 32 until the start of tick 102 of line 33. It therefore falls on the first active vck_o edge. Mode does not change this timing.
- R5: In 16:9 mode, an active line with (line − 33) mod 4 = 3 is eliminated: it has no en_o pulse and no vck_o edge. This leaves 171 vck_o edges per frame.
- R6: In 16:9 mode, wide_line_o is 1 during ticks 89..124 of every line: it rises 13 ticks before the vck_o edge position and lasts 36 ticks. In 4:3 mode wide_line_o is 0. wide_line_o is never 1 while en_o is 1.
- R7: In 16:9 mode, wide_frame_o is 1 on lines 0..29 and 0 elsewhere. It is 0 throughout 4:3 mode. Its falling edge is at least 300 ticks away from any rising edge of en_o.
- R8: mode169_i (1 = 16:9, 0 = 4:3) and scan_down_i are sampled only at the strobe that starts line 0. A change at any other time has no effect on the outputs until that strobe.
- R9: scan_down_o carries the captured direction: 1 selects top-to-bottom scan, 0 selects bottom-to-top scan. It changes only at a frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe_i | input | 1 | One-cycle pulse marking the start of a line |
| mode169_i | input | 1 | 1 selects 16:9 letterbox mode, 0 selects 4:3 |
| scan_down_i | input | 1 | Requested scan direction, 1 = top to bottom |
| vst_o | output | 1 | Vertical start pulse |
| vck_o | output | 1 | Vertical shift clock, both edges active |
| en_o | output | 1 | Gate enable pulse |
| wide_line_o | output | 1 | Per-line letterbox pulse |
| wide_frame_o | output | 1 | Frame-level letterbox window |
| scan_down_o | output | 1 | Captured scan direction sent to the panel |

## Verification
All counters in the block load on the clock edge that samples a strobe, and the outputs are decoded from those counters. As a result, en_o, vst_o and both letterbox outputs take their new values in the very cycle whose tick number matches. vck_o is a register triggered one tick early, so its edge also lands at the start of tick 102. A mode or direction change shows up only from the first cycle of the next frame. The bench carries its own tick, line, mode and clock-level state. It advances that state at each falling clock edge, on exactly that schedule, and compares every output in every cycle. It also counts vck_o edges per frame and checks, across a mid-frame control change, that the current frame's outputs are unaffected.

// File: rtl/lcd_vscan_pkg.sv
package lcd_vscan_pkg;

  typedef struct packed {
    logic wide;   // 16:9 letterbox operation
    logic down;   // top-to-bottom scan
  } scan_cfg_t;

  // half-open interval test [lo, hi)
  function automatic logic in_span(input int unsigned v,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v < hi);
  endfunction

  // last slot of a repeating group of 'period' lines
  function automatic logic is_last_slot(input int unsigned ph,
                                        input int unsigned period);
    return (ph + 1) == period;
  endfunction

endpackage

// File: rtl/lcd_vscan_seq.sv
module lcd_vscan_seq
  import lcd_vscan_pkg::*;
#(
  parameter int unsigned FRAME_LINES = 262,
  parameter int unsigned ACT_START   = 33,
  parameter int unsigned ELIM_PERIOD = 4,
  parameter int unsigned TICK_W      = 10,
  parameter int unsigned LINE_W      = 9,
  parameter int unsigned PH_W        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_strobe_i,
  input  logic              mode169_i,
  input  logic              scan_down_i,
  output logic [TICK_W-1:0] tick_o,
  output logic [LINE_W-1:0] line_o,
  output logic [PH_W-1:0]   phase_o,
  output scan_cfg_t         cfg_o,
  output logic              frame_wrap_o
);

  localparam logic [TICK_W-1:0] TICK_MAX = '1;

  logic [TICK_W-1:0] tick_q;
  logic [LINE_W-1:0] line_q;
  logic [PH_W-1:0]   ph_q;
  scan_cfg_t         cfg_q;
  logic              last_line_w;
  logic              pre_active_w;

  assign last_line_w  = (32'(line_q) == FRAME_LINES - 1);
  assign pre_active_w = (32'(line_q) == ACT_START - 1);
  assign frame_wrap_o = line_strobe_i && last_line_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= TICK_MAX;
      line_q <= LINE_W'(FRAME_LINES - 1);
      ph_q   <= '0;
      cfg_q  <= '{wide: 1'b0, down: 1'b1};
    end else if (line_strobe_i) begin
      tick_q <= '0;
      line_q <= last_line_w ? '0 : line_q + LINE_W'(1);
      if (pre_active_w || is_last_slot(32'(ph_q), ELIM_PERIOD)) begin
        ph_q <= '0;
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
      if (last_line_w) begin
        cfg_q <= '{wide: mode169_i, down: scan_down_i};
      end
    end else if (tick_q != TICK_MAX) begin
      tick_q <= tick_q + TICK_W'(1);
    end
  end

  assign tick_o  = tick_q;
  assign line_o  = line_q;
  assign phase_o = ph_q;
  assign cfg_o   = cfg_q;

endmodule

// File: rtl/lcd_vscan_decode.sv
module lcd_vscan_decode
  import lcd_vscan_pkg::*;
#(
  parameter int unsigned ACTIVE_LINES = 228,
  parameter int unsigned ACT_START    = 33,
  parameter int unsigned WIDE_LINES   = 30,
  parameter int unsigned ELIM_PERIOD  = 4,
  parameter int unsigned EN_RISE      = 6,
  parameter int unsigned EN_FALL      = 72,
  parameter int unsigned VCK_TICK     = 102,
  parameter int unsigned WL_LEAD      = 13,
  parameter int unsigned WL_WIDTH     = 36,
  parameter int unsigned TICK_W       = 10,
  parameter int unsigned LINE_W       = 9,
  parameter int unsigned PH_W         = 2
) (
  input  logic [TICK_W-1:0] tick_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              wide_i,
  output logic              clk_line_o,
  output logic              elim_o,
  output logic              en_o,
  output logic              vst_o,
  output logic              wide_line_o,
  output logic              wide_frame_o
);

  localparam int unsigned ACT_END  = ACT_START + ACTIVE_LINES;
  localparam int unsigned WL_RISE  = VCK_TICK - WL_LEAD;
  localparam int unsigned WL_FALL  = WL_RISE + WL_WIDTH;

  logic [31:0] t;
  logic [31:0] l;
  logic        act_w;

  assign t     = 32'(tick_i);
  assign l     = 32'(line_i);
  assign act_w = in_span(l, ACT_START, ACT_END);

  assign elim_o       = wide_i && act_w && is_last_slot(32'(phase_i), ELIM_PERIOD);
  assign clk_line_o   = act_w && !elim_o;
  assign en_o         = clk_line_o && in_span(t, EN_RISE, EN_FALL);
  assign vst_o        = ((l == ACT_START - 1) && (t >= VCK_TICK)) ||
                        ((l == ACT_START)     && (t <  VCK_TICK));
  assign wide_line_o  = wide_i && in_span(t, WL_RISE, WL_FALL);
  assign wide_frame_o = wide_i && (l < WIDE_LINES);

endmodule

// File: rtl/lcd_vscan_vclk.sv
module lcd_vscan_vclk #(
  parameter int unsigned TICK_W   = 10,
  parameter int unsigned VCK_TICK = 102
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              clk_line_i,
  output logic              step_o,
  output logic              vck_o
);

  logic vck_q;

  // fire one tick early so the new level is visible from tick VCK_TICK
  assign step_o = clk_line_i && (tick_i == TICK_W'(VCK_TICK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vck_q <= 1'b0;
    end else if (step_o) begin
      vck_q <= !vck_q;
    end
  end

  assign vck_o = vck_q;

endmodule

// File: rtl/lcd_vscan_gen.sv
module lcd_vscan_gen
  import lcd_vscan_pkg::*;
#(
  parameter int unsigned FRAME_LINES  = 262,
  parameter int unsigned ACTIVE_LINES = 228,
  parameter int unsigned ACT_START    = 33,
  parameter int unsigned WIDE_LINES   = 30,
  parameter int unsigned ELIM_PERIOD  = 4,
  parameter int unsigned EN_RISE      = 6,
  parameter int unsigned EN_FALL      = 72,
  parameter int unsigned VCK_TICK     = 102,
  parameter int unsigned WL_LEAD      = 13,
  parameter int unsigned WL_WIDTH     = 36,
  parameter int unsigned TICK_W       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_strobe_i,
  input  logic mode169_i,
  input  logic scan_down_i,
  output logic vst_o,
  output logic vck_o,
  output logic en_o,
  output logic wide_line_o,
  output logic wide_frame_o,
  output logic scan_down_o
);

  localparam int unsigned LINE_W = $clog2(FRAME_LINES);
  localparam int unsigned PH_W   = (ELIM_PERIOD > 1) ? $clog2(ELIM_PERIOD) : 1;

  // named internal events, visible to the bound checker
  logic [TICK_W-1:0] tick_w;
  logic [LINE_W-1:0] line_w;
  logic [PH_W-1:0]   phase_w;
  scan_cfg_t         cfg_w;
  logic              frame_wrap_w;
  logic              clk_line_w;
  logic              line_elim_w;
  logic              vck_step_w;

  lcd_vscan_seq #(
    .FRAME_LINES (FRAME_LINES),
    .ACT_START   (ACT_START),
    .ELIM_PERIOD (ELIM_PERIOD),
    .TICK_W      (TICK_W),
    .LINE_W      (LINE_W),
    .PH_W        (PH_W)
  ) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_strobe_i (line_strobe_i),
    .mode169_i     (mode169_i),
    .scan_down_i   (scan_down_i),
    .tick_o        (tick_w),
    .line_o        (line_w),
    .phase_o       (phase_w),
    .cfg_o         (cfg_w),
    .frame_wrap_o  (frame_wrap_w)
  );

  lcd_vscan_decode #(
    .ACTIVE_LINES (ACTIVE_LINES),
    .ACT_START    (ACT_START),
    .WIDE_LINES   (WIDE_LINES),
    .ELIM_PERIOD  (ELIM_PERIOD),
    .EN_RISE      (EN_RISE),
    .EN_FALL      (EN_FALL),
    .VCK_TICK     (VCK_TICK),
    .WL_LEAD      (WL_LEAD),
    .WL_WIDTH     (WL_WIDTH),
    .TICK_W       (TICK_W),
    .LINE_W       (LINE_W),
    .PH_W         (PH_W)
  ) dec_i (
    .tick_i       (tick_w),
    .line_i       (line_w),
    .phase_i      (phase_w),
    .wide_i       (cfg_w.wide),
    .clk_line_o   (clk_line_w),
    .elim_o       (line_elim_w),
    .en_o         (en_o),
    .vst_o        (vst_o),
    .wide_line_o  (wide_line_o),
    .wide_frame_o (wide_frame_o)
  );

  lcd_vscan_vclk #(
    .TICK_W   (TICK_W),
    .VCK_TICK (VCK_TICK)
  ) vclk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_w),
    .clk_line_i (clk_line_w),
    .step_o     (vck_step_w),
    .vck_o      (vck_o)
  );

  assign scan_down_o = cfg_w.down;

endmodule

// File: rtl/lcd_vscan_chk.sv
module lcd_vscan_chk #(
  parameter int unsigned TICK_W      = 10,
  parameter int unsigned EN_RISE     = 6,
  parameter int unsigned EN_FALL     = 72,
  parameter int unsigned VCK_TICK    = 102,
  parameter int unsigned GUARD_TICKS = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TICK_W-1:0] tick_i,
  input logic              frame_wrap_i,
  input logic              elim_i,
  input logic              en_i,
  input logic              vck_i,
  input logic              vst_i,
  input logic              wide_line_i,
  input logic              wide_frame_i,
  input logic              down_i
);

  localparam int unsigned CW = 16;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] en_hi_run;
  logic [CW-1:0] en_lo_run;
  logic [CW-1:0] since_en_rise;
  logic [CW-1:0] since_wf_fall;
  logic          en_d;
  logic          wf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_hi_run     <= '0;
      en_lo_run     <= '0;
      since_en_rise <= CMAX;
      since_wf_fall <= CMAX;
      en_d          <= 1'b0;
      wf_d          <= 1'b0;
    end else begin
      en_d <= en_i;
      wf_d <= wide_frame_i;
      en_hi_run <= en_i ? ((en_hi_run != CMAX) ? en_hi_run + CW'(1) : en_hi_run) : '0;
      en_lo_run <= en_i ? '0 : ((en_lo_run != CMAX) ? en_lo_run + CW'(1) : en_lo_run);
      if (en_i && !en_d) since_en_rise <= CW'(1);
      else if (since_en_rise != CMAX) since_en_rise <= since_en_rise + CW'(1);
      if (!wide_frame_i && wf_d) since_wf_fall <= CW'(1);
      else if (since_wf_fall != CMAX) since_wf_fall <= since_wf_fall + CW'(1);
    end
  end

  // R2
  vck_tick_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vck_i != $past(vck_i)) |-> (32'(tick_i) == VCK_TICK));

  // R3
  en_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_i) |-> (en_hi_run == CW'(EN_FALL - EN_RISE)));

  // R3
  en_lead_vck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vck_i != $past(vck_i)) |-> (!en_i && (en_lo_run >= CW'(VCK_TICK - EN_FALL))));

  // R4
  vst_end_on_vck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vst_i) |-> (vck_i != $past(vck_i)));

  // R5
  elim_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elim_i |-> (!en_i && $stable(vck_i)));

  // R6
  wide_line_en_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && wide_line_i));

  // R7
  wf_fall_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wide_frame_i) |-> (since_en_rise >= CW'(GUARD_TICKS)));

  // R7
  en_rise_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> (since_wf_fall >= CW'(GUARD_TICKS)));

  // R8
  wf_start_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wide_frame_i) |-> $past(frame_wrap_i));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap_i |=> $stable(down_i));

endmodule

bind lcd_vscan_gen lcd_vscan_chk #(
  .TICK_W   (TICK_W),
  .EN_RISE  (EN_RISE),
  .EN_FALL  (EN_FALL),
  .VCK_TICK (VCK_TICK)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_w),
  .frame_wrap_i (frame_wrap_w),
  .elim_i       (line_elim_w),
  .en_i         (en_o),
  .vck_i        (vck_o),
  .vst_i        (vst_o),
  .wide_line_i  (wide_line_o),
  .wide_frame_i (wide_frame_o),
  .down_i       (scan_down_o)
);

// File: tb/lcd_vscan_gen_tb_top.sv
module lcd_vscan_gen_tb_top;

  localparam int LINE  = 128;   // cycles between line strobes
  localparam int FRAME = 262;
  localparam int ACT0  = 33;
  localparam int NACT  = 228;
  localparam int WLN   = 30;
  localparam int EPER  = 4;
  localparam int ENR   = 6;
  localparam int ENF   = 72;
  localparam int VCKT  = 102;
  localparam int WLR   = 89;
  localparam int WLF   = 125;
  localparam int TMAX  = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic mode_i = 1'b0;
  logic down_i = 1'b1;
  logic vst, vck, en, wl, wf, down_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  lcd_vscan_gen dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_strobe_i (strobe),
    .mode169_i     (mode_i),
    .scan_down_i   (down_i),
    .vst_o         (vst),
    .vck_o         (vck),
    .en_o          (en),
    .wide_line_o   (wl),
    .wide_frame_o  (wf),
    .scan_down_o   (down_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit clocked_line(input int line, input bit mode);
    bit act;
    act = (line >= ACT0) && (line < ACT0 + NACT);
    if (!act) return 1'b0;
    if (mode && (((line - ACT0) % EPER) == EPER - 1)) return 1'b0;
    return 1'b1;
  endfunction

  // behavioural reference state
  int m_tick, m_line, cyc, frames, toggles;
  bit m_vck, m_mode, m_down, prev_vck;
  bit e_en, e_vst, e_wl, e_wf;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_tick = TMAX; m_line = FRAME - 1; m_vck = 0; m_mode = 0; m_down = 1;
      cyc = 0; frames = 0; toggles = 0; prev_vck = 0; strobe = 0;
    end else if (!done) begin
      e_en  = clocked_line(m_line, m_mode) && (m_tick >= ENR) && (m_tick < ENF);
      e_vst = ((m_line == ACT0 - 1) && (m_tick >= VCKT)) ||
              ((m_line == ACT0) && (m_tick < VCKT));
      e_wl  = m_mode && (m_tick >= WLR) && (m_tick < WLF);
      e_wf  = m_mode && (m_line < WLN);
      chk(vck === m_vck,   "R2 R5 vertical clock level", vck, m_vck);
      chk(en === e_en,     "R3 R5 enable", en, e_en);
      chk(vst === e_vst,   "R1 R4 start pulse", vst, e_vst);
      chk(wl === e_wl,     "R6 line letterbox pulse", wl, e_wl);
      chk(wf === e_wf,     "R7 frame letterbox window", wf, e_wf);
      chk(down_o === m_down, "R9 scan direction", down_o, m_down);
      if (vck !== prev_vck) toggles++;
      prev_vck = vck;

      strobe = ((cyc % LINE) == 0);
      cyc++;

      if (m_tick == VCKT - 1 && clocked_line(m_line, m_mode)) m_vck = !m_vck;
      if (strobe) begin
        m_tick = 0;
        if (m_line == FRAME - 1) begin
          if (frames > 0)
            chk(toggles == (m_mode ? NACT - NACT / EPER : NACT),
                "R2 R5 vck edges per frame", toggles,
                m_mode ? NACT - NACT / EPER : NACT);
          frames++;
          toggles = 0;
          m_line = 0;
          m_mode = mode_i;
          m_down = down_i;
        end else begin
          m_line++;
        end
      end else if (m_tick < TMAX) begin
        m_tick++;
      end
    end
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({vst, vck, en, wl, wf} === 5'b0, "R1 reset outputs low", {vst, vck, en, wl, wf}, 0);
    chk(down_o === 1'b1, "R1 reset direction", down_o, 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // frame A in 4:3 top-to-bottom; change controls mid-frame
    repeat (100 * LINE) @(posedge clk);
    #1 mode_i = 1'b1; down_i = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < LINE; i++) begin
      @(negedge clk);
      if (wl !== 1'b0 || wf !== 1'b0 || down_o !== 1'b1) ok = 1'b0;
    end
    chk(ok, "R8 mid-frame change ignored (4:3 frame)", {wl, wf, down_o}, 1);

    // frame B runs 16:9 bottom-to-top; change back mid-frame
    repeat (FRAME * LINE) @(posedge clk);
    #1 mode_i = 1'b0; down_i = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < LINE; i++) begin
      @(negedge clk);
      if (down_o !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R8 mid-frame change ignored (16:9 frame)", down_o, 0);

    // frame C in 4:3 again, then into frame D
    repeat (FRAME * LINE) @(posedge clk);
    repeat ((FRAME - 100) * LINE) @(posedge clk);
    chk(frames == 4, "R1 frame count", frames, 4);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule